// File: doc/BRIEF.md
# Three-Level Page Table Walker for 39-bit Virtual Addresses

This block translates a 39-bit virtual address into a 56-bit physical address. It reads page table entries from memory, one level at a time, starting from a root table base. At each level it takes a 9-bit slice of the virtual page number and uses it to pick an 8-byte entry from the current table. The entry it reads either points to the next table, ends the walk as a leaf, or raises a fault.

A client raises `start` for one cycle with the address, the root base, the starting level, the access kind, the privilege and the two relaxation flags. The walker then issues one memory read at a time over a simple request/response port. When the walk ends it pulses `done` for one cycle. At that point it presents either a translation or one of four fault codes. A translation comes with the leaf entry, the address of that entry, the level where the leaf was found and an accumulated global flag. The results stay on the outputs until the next walk finishes.

Top module: `sv39_walker`

## Requirements
- R1: Each read goes to address `base + 8*idx`. Here `idx = (vaddr[38:12] >> 9*level) & 0x1FF`. The base is `root_base` for the first read and `next_ppn << 12` after a pointer. The `pte_addr` output reports the address of the final read.
- R2: A read answered with `mem_rsp_err=1` ends the walk with `fault=1` and `fault_code=0` (access fault).
- R3: An entry whose bit 0 (valid) is 0 is invalid. An entry with bit 2 (write) set and bit 1 (read) clear is also invalid. Either case ends the walk with `fault_code=1`.
- R4: A valid entry with bits 1, 2 and 3 all zero is a pointer. At level above 0 it moves the walk one level down, to the table at PPN `pte[53:10]`. At level 0 it ends the walk with `fault_code=1`. The number of reads equals the number of levels visited.
- R5: A leaf that fails the permission check ends the walk with `fault_code=2`. Access type 0 (read) needs bit 1, or bit 3 when `mxr=1`. Type 1 (write) needs bit 2. Type 2 (execute) needs bit 3. Type 3 always fails. In user mode (`priv_user=1`), bit 4 (user) must be set. In supervisor mode, a page with bit 4 set is allowed only when `sum=1` and the access is not execute.
- R6: A permitted leaf at level L > 0 whose PPN has any of its low 9*L bits set ends the walk with `fault_code=3` (misaligned).
- R7: A permitted, aligned leaf ends the walk with `fault=0` and `paddr = {ppn | (vpn & mask), vaddr[11:0]}`, where mask has 9*L low ones. Level 0 uses the PPN unchanged. The outputs `leaf_pte` and `leaf_level` report the leaf entry and the level where it was found.
- R8: On success, `global_out` is the OR of `global_in` and bit 5 of every entry read during the walk.
- R9: At most one read is outstanding. `mem_req` is a single-cycle pulse and `done` is a single-cycle pulse. A `start` that arrives while `busy=1` has no effect on the walk in progress.
- R10: After reset, `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a walk when the block is idle |
| vaddr | input | 39 | Virtual address to translate |
| root_base | input | 56 | Byte address of the first table |
| start_level | input | 2 | First level to walk (values above 2 are treated as 2) |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| priv_user | input | 1 | 1 user mode, 0 supervisor mode |
| mxr | input | 1 | Lets executable pages be read |
| sum | input | 1 | Lets supervisor mode touch user pages |
| global_in | input | 1 | Initial value of the global flag |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 56 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Read response carries an error |
| mem_rsp_data | input | 64 | Entry read from memory |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Result pulse |
| fault | output | 1 | The walk ended in a fault |
| fault_code | output | 2 | 0 access, 1 invalid, 2 permission, 3 misaligned |
| paddr | output | 56 | Translated physical address |
| leaf_pte | output | 64 | Final entry read |
| pte_addr | output | 56 | Address of the final entry read |
| leaf_level | output | 2 | Level where the walk ended |
| global_out | output | 1 | Accumulated global flag |

## Verification
A wrong level counter or table base shows up at the ports straight away. The next `mem_addr` would carry a bad index or a bad base, and the number of read pulses before `done` would change. Both are visible within one walk, which lasts at most three reads. A bad classification of an entry shows up as a wrong `fault_code`, or as a wrong `paddr` in the cycle that `done` rises. A global flag that fails to accumulate shows only at the end of a walk, and only when an upper-level pointer carried bit 5. The random walks therefore set bit 5 on upper levels independently of the leaf.

// File: rtl/sv39_walker.sv
module sv39_walker #(
  parameter int PA_W     = 56,
  parameter int VA_W     = 39,
  parameter int PTE_W    = 64,
  parameter int LVL_BITS = 9,
  parameter int PG_BITS  = 12,
  parameter int TOP_LVL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PA_W-1:0]   root_base,
  input  logic [1:0]        start_level,
  input  logic [1:0]        acc_type,
  input  logic              priv_user,
  input  logic              mxr,
  input  logic              sum,
  input  logic              global_in,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [PA_W-1:0]   paddr,
  output logic [PTE_W-1:0]  leaf_pte,
  output logic [PA_W-1:0]   pte_addr,
  output logic [1:0]        leaf_level,
  output logic              global_out
);
  localparam int VPN_W   = VA_W - PG_BITS;
  localparam int PPN_W   = PA_W - PG_BITS;
  localparam int PPN_LSB = 10;
  localparam logic [1:0] F_ACC = 2'd0, F_INV = 2'd1, F_PERM = 2'd2, F_MIS = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [1:0]       lvl;
  logic [PA_W-1:0]  base;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             usr_q, mxr_q, sum_q, glob_q;

  logic [VPN_W-1:0]    vpn;
  logic [PPN_W-1:0]    vpn_x, ppn, mask, ppn_out;
  logic [4:0]          sh;
  logic [LVL_BITS-1:0] idx;
  logic v, r, w, x, u, g;
  logic invalid, is_ptr, perm_ok, misal;

  assign vpn     = va_q[VA_W-1:PG_BITS];
  assign vpn_x   = PPN_W'(vpn);
  assign sh      = 5'(lvl) * 5'(LVL_BITS);
  assign idx     = LVL_BITS'(vpn >> sh);
  assign mem_addr = base + PA_W'({idx, 3'b000});
  assign mem_req = (st == S_REQ);
  assign busy    = (st != S_IDLE);

  assign {g, u, x, w, r, v} = mem_rsp_data[5:0];
  assign ppn     = mem_rsp_data[PPN_LSB +: PPN_W];
  assign mask    = (PPN_W'(1) << sh) - PPN_W'(1);
  assign misal   = |(ppn & mask);
  assign ppn_out = ppn | (vpn_x & mask);
  assign invalid = !v || (w && !r);
  assign is_ptr  = !r && !w && !x;

  always_comb begin
    case (acc_q)
      2'd0:    perm_ok = r || (mxr_q && x);
      2'd1:    perm_ok = w;
      2'd2:    perm_ok = x;
      default: perm_ok = 1'b0;
    endcase
    if (usr_q)  perm_ok = perm_ok && u;
    else if (u) perm_ok = perm_ok && sum_q && (acc_q != 2'd2);
  end

  logic       fin, fin_fault, descend;
  logic [1:0] fin_code;
  always_comb begin
    fin = 1'b0; fin_fault = 1'b1; fin_code = F_ACC; descend = 1'b0;
    if (st == S_WAIT && mem_rsp_valid) begin
      fin = 1'b1;
      if (mem_rsp_err)     fin_code = F_ACC;
      else if (invalid)    fin_code = F_INV;
      else if (is_ptr) begin
        if (lvl != 2'd0) begin fin = 1'b0; descend = 1'b1; end
        else fin_code = F_INV;
      end
      else if (!perm_ok)   fin_code = F_PERM;
      else if (misal)      fin_code = F_MIS;
      else                 fin_fault = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; lvl <= '0; base <= '0; va_q <= '0; acc_q <= '0;
      usr_q <= 1'b0; mxr_q <= 1'b0; sum_q <= 1'b0; glob_q <= 1'b0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0; paddr <= '0;
      leaf_pte <= '0; pte_addr <= '0; leaf_level <= '0; global_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_REQ;
          lvl    <= (start_level > 2'(TOP_LVL)) ? 2'(TOP_LVL) : start_level;
          base   <= root_base;
          va_q   <= vaddr;
          acc_q  <= acc_type;
          usr_q  <= priv_user;
          mxr_q  <= mxr;
          sum_q  <= sum;
          glob_q <= global_in;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (descend) begin
            st     <= S_REQ;
            lvl    <= lvl - 2'd1;
            base   <= {ppn, {PG_BITS{1'b0}}};
            glob_q <= glob_q | g;
          end else if (fin) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            fault      <= fin_fault;
            fault_code <= fin_fault ? fin_code : 2'd0;
            paddr      <= fin_fault ? '0 : {ppn_out, va_q[PG_BITS-1:0]};
            leaf_pte   <= mem_rsp_data;
            pte_addr   <= mem_addr;
            leaf_level <= lvl;
            global_out <= glob_q | (g && !mem_rsp_err);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !(st == S_WAIT && mem_rsp_valid)) |=> busy);
  // R9
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req);
  // R6
  mis_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault && fault_code == F_MIS) |-> leaf_level != 2'd0);
  // R7
  ok_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> paddr[PG_BITS-1:0] == va_q[PG_BITS-1:0]);
endmodule

// File: tb/tb_sv39_walker.sv
`timescale 1ns/1ps
module tb_sv39_walker;
  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [38:0] vaddr = '0;
  logic [55:0] root_base = '0;
  logic [1:0] start_level = 2'd2, acc_type = '0;
  logic priv_user = 0, mxr = 0, sum = 0, global_in = 0;
  logic mem_req; logic [55:0] mem_addr;
  logic mem_rsp_valid = 0, mem_rsp_err = 0; logic [63:0] mem_rsp_data = '0;
  logic busy, done, fault, global_out;
  logic [1:0] fault_code, leaf_level;
  logic [55:0] paddr, pte_addr; logic [63:0] leaf_pte;

  sv39_walker dut (.*);

  always #4 clk = ~clk;

  logic [63:0] mem [logic [55:0]];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  function automatic logic [55:0] ent_addr(input logic [55:0] b, input logic [38:0] va, input int l);
    logic [8:0] ix;
    ix = 9'((va >> (12 + 9*l)));
    return b + 56'({ix, 3'b000});
  endfunction

  task automatic ref_walk(input logic [38:0] va, input logic [55:0] root, input int sl,
      input logic [1:0] acc, input bit usr, input bit mx, input bit sm, input bit gin,
      output bit f, output logic [1:0] code, output logic [55:0] pa,
      output logic [63:0] pte, output logic [55:0] pa_pte, output int lv,
      output bit g, output int nrd);
    logic [55:0] b, a; int l; bit ok; logic [43:0] m, pp, vpn;
    b = root; l = sl; g = gin; nrd = 0; f = 0; code = 0; pa = '0; pte = '0;
    vpn = 44'(va[38:12]);
    forever begin
      a = ent_addr(b, va, l); nrd++; pa_pte = a; lv = l;
      if (!mem.exists(a)) begin f = 1; code = 0; break; end
      pte = mem[a];
      if (!pte[0] || (pte[2] && !pte[1])) begin f = 1; code = 1; break; end
      g = g | pte[5];
      if (!pte[1] && !pte[2] && !pte[3]) begin
        if (l == 0) begin f = 1; code = 1; break; end
        b = {pte[53:10], 12'b0}; l--; continue;
      end
      case (acc)
        2'd0: ok = pte[1] || (mx && pte[3]);
        2'd1: ok = pte[2];
        2'd2: ok = pte[3];
        default: ok = 0;
      endcase
      if (usr) ok = ok && pte[4];
      else if (pte[4]) ok = ok && sm && acc != 2'd2;
      if (!ok) begin f = 1; code = 2; break; end
      m = (44'd1 << (9*l)) - 44'd1;
      pp = pte[53:10];
      if ((pp & m) != 0) begin f = 1; code = 3; break; end
      pa = {pp | (vpn & m), va[11:0]};
      break;
    end
  endtask

  task automatic build(input logic [38:0] va, input logic [55:0] root, input int sl,
      input int ll, input logic [63:0] leaf, input logic [2:0] gm, input bit omit);
    logic [55:0] b; logic [43:0] t;
    b = root;
    for (int l = sl; l > ll; l--) begin
      t = {30'h0, 2'(l), 12'($urandom)};
      mem[ent_addr(b, va, l)] = mk_pte(t, 8'h01 | (8'(gm[l]) << 5));
      b = {t, 12'b0};
    end
    if (!omit) mem[ent_addr(b, va, ll)] = leaf;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_req) begin
        logic [55:0] a;
        a = mem_addr;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        mem_rsp_valid = 1;
        if (mem.exists(a)) begin mem_rsp_err = 0; mem_rsp_data = mem[a]; end
        else begin mem_rsp_err = 1; mem_rsp_data = {$urandom, $urandom}; end
      end
    end
  end

  bit        o_f; logic [1:0] o_code;

  task automatic run_walk(input logic [38:0] va, input logic [55:0] root, input int sl,
      input logic [1:0] acc, input bit usr, input bit mx, input bit sm, input bit gin,
      input bit poke, input string tag);
    bit ef, eg; logic [1:0] ec; logic [55:0] epa, epa_pte; logic [63:0] epte;
    int elv, enrd, nreq, cyc;
    ref_walk(va, root, sl, acc, usr, mx, sm, gin, ef, ec, epa, epte, epa_pte, elv, eg, enrd);
    @(negedge clk);
    vaddr = va; root_base = root; start_level = 2'(sl); acc_type = acc;
    priv_user = usr; mxr = mx; sum = sm; global_in = gin; start = 1;
    nreq = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      start = 0;
      if (poke && cyc == 1) begin vaddr = ~va; root_base = ~root; acc_type = 2'd3; start = 1; end
      if (mem_req) nreq++;
      if (done || cyc > 200) break;
    end
    o_f = fault; o_code = fault_code;
    chk(done, "R9", {tag, " done"}, 64'(done), 64'd1);
    chk(fault == ef, ef ? "R2" : "R7", {tag, " fault"}, 64'(fault), 64'(ef));
    if (ef) chk(fault_code == ec, "R5", {tag, " code"}, 64'(fault_code), 64'(ec));
    chk(nreq == enrd, "R4", {tag, " reads"}, 64'(nreq), 64'(enrd));
    chk(pte_addr == epa_pte, "R1", {tag, " pte_addr"}, 64'(pte_addr), 64'(epa_pte));
    if (!ef) begin
      chk(paddr == epa, "R7", {tag, " paddr"}, 64'(paddr), 64'(epa));
      chk(leaf_pte == epte, "R7", {tag, " leaf_pte"}, leaf_pte, epte);
      chk(leaf_level == 2'(elv), "R7", {tag, " level"}, 64'(leaf_level), 64'(elv));
      chk(global_out == eg, "R8", {tag, " global"}, 64'(global_out), 64'(eg));
    end
    @(negedge clk);
    chk(!done, "R9", {tag, " done pulse"}, 64'(done), 64'd0);
  endtask

  localparam logic [38:0] VA = 39'h12_3456_7ABC;
  localparam logic [55:0] RT = 56'h80_0000;

  initial begin
    void'($urandom(32'd4242));
    #3;
    chk(!busy && !done && !mem_req, "R10", "reset outputs", {61'b0, busy, done, mem_req}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!busy && !done && !mem_req, "R10", "after reset", {61'b0, busy, done, mem_req}, 64'd0);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h1234, 8'h17), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 1, 0, 0, 0, 0, "4k user read");
    chk(!o_f, "R7", "4k ok", 64'(o_f), 64'd0);

    mem.delete(); build(VA, RT, 2, 0, 0, 3'b000, 1);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "missing leaf");
    chk(o_f && o_code == 0, "R2", "access fault", 64'(o_code), 64'd0);

    mem.delete(); build(VA, RT, 2, 1, mk_pte(44'h200, 8'h0E), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "V clear");
    chk(o_f && o_code == 1, "R3", "invalid V", 64'(o_code), 64'd1);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h55, 8'h05), 3'b000, 0);
    run_walk(VA, RT, 2, 1, 0, 0, 0, 0, 0, "W no R");
    chk(o_f && o_code == 1, "R3", "invalid WnoR", 64'(o_code), 64'd1);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h55, 8'h01), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "ptr at L0");
    chk(o_f && o_code == 1, "R4", "pointer at level 0", 64'(o_code), 64'd1);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h77, 8'h03), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 1, 0, 0, 0, 0, "user on S page");
    chk(o_f && o_code == 2, "R5", "user on S page", 64'(o_code), 64'd2);
    run_walk(VA, RT, 2, 1, 0, 0, 0, 0, 0, "write R-only");
    chk(o_f && o_code == 2, "R5", "write R-only", 64'(o_code), 64'd2);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h77, 8'h1B), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "S on U no sum");
    chk(o_f && o_code == 2, "R5", "S on U without sum", 64'(o_code), 64'd2);
    run_walk(VA, RT, 2, 0, 0, 0, 1, 0, 0, "S on U sum");
    chk(!o_f, "R5", "S on U with sum read", 64'(o_f), 64'd0);
    run_walk(VA, RT, 2, 2, 0, 0, 1, 0, 0, "S exec U sum");
    chk(o_f && o_code == 2, "R5", "S exec U page", 64'(o_code), 64'd2);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h77, 8'h09), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "X-only no mxr");
    chk(o_f && o_code == 2, "R5", "X-only read no mxr", 64'(o_code), 64'd2);
    run_walk(VA, RT, 2, 0, 0, 1, 0, 0, 0, "X-only mxr");
    chk(!o_f, "R5", "X-only read with mxr", 64'(o_f), 64'd0);

    mem.delete(); build(VA, RT, 2, 1, mk_pte(44'h402, 8'h03), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "2M misaligned");
    chk(o_f && o_code == 3, "R6", "2M misaligned", 64'(o_code), 64'd3);

    mem.delete(); build(VA, RT, 2, 1, mk_pte(44'h400, 8'h03), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "2M aligned");
    chk(!o_f, "R7", "2M aligned", 64'(o_f), 64'd0);

    mem.delete(); build(VA, RT, 2, 2, mk_pte(44'h4_0000, 8'h0B), 3'b000, 0);
    run_walk(VA, RT, 2, 2, 0, 0, 0, 0, 0, "1G exec");
    chk(!o_f, "R7", "1G aligned", 64'(o_f), 64'd0);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h99, 8'h03), 3'b100, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 0, "G on root ptr");
    chk(global_out, "R8", "global from pointer", 64'(global_out), 64'd1);

    mem.delete(); build(VA, RT, 2, 0, mk_pte(44'h99, 8'h03), 3'b000, 0);
    run_walk(VA, RT, 2, 0, 0, 0, 0, 0, 1, "start while busy");
    chk(!o_f, "R9", "walk unaffected by second start", 64'(o_f), 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [38:0] va; logic [55:0] rt; int sl, ll; logic [43:0] pp; logic [7:0] fl;
      va = {$urandom, $urandom};
      rt = {24'h0, 20'($urandom), 12'h0};
      sl = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : 2;
      ll = $urandom_range(0, sl);
      pp = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) pp = pp & ~((44'd1 << (9*ll)) - 44'd1);
      fl = 8'($urandom);
      if ($urandom_range(0, 3) != 0) fl[0] = 1;
      mem.delete();
      build(va, rt, sl, ll, mk_pte(pp, fl), 3'($urandom), $urandom_range(0, 15) == 0);
      run_walk(va, rt, sl, 2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 0, "random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule